// File: doc/BRIEF.md
# Radix-4 SRT Significand Divider

This block divides two normalized 24-bit significands using a sequential radix-4 digit recurrence. Each iteration produces one signed quotient digit from the set {-2, -1, 0, +1, +2}, which is two quotient bits. The caller scales the divisor into [1/2, 1) by setting its top bit. The caller scales the dividend into (0, d) by making its integer value smaller than the divisor's. The block halves the dividend to form the first partial remainder, so the remainder stays inside the convergence bound of the minimally redundant digit set.

Two selection thresholds choose each digit. The first partial remainder is the shifted dividend itself (the prescaled x/2). At every step that remainder is shifted left by two bits (multiplied by 4) and compared, in full precision two's complement, against the thresholds. The thresholds come from a short closed-form sum of the three divisor bits below the leading one. No divisor interval is looked up in a table.

The signed digits are folded into a binary quotient as they arrive, using a pair of registers that differ by one unit in the last place. If the final remainder is negative, it is corrected by one divisor and the quotient is taken from the lower register. The result is a 25-bit truncated quotient, which is 24 bits plus a guard bit, together with the exact nonnegative remainder. Sign, exponent and rounding belong to the surrounding logic.

Top module: `srt4_divider`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `done`, `quotient` and `remainder` are all zero.
- R2: A `start` sampled high while `busy` is low is accepted at that clock edge. `busy` is high from the next cycle until the completion edge, which is 14 edges after the accepting edge. At the completion edge `busy` falls and `done` rises.
- R3: With dividend integer X and divisor integer D (D[23] = 1, 0 < X < D), `quotient` equals floor(X * 2^25 / D). This is the value of x/d with its most significant bit weighted 1/2.
- R4: `remainder` equals X * 2^25 - quotient * D, and always satisfies 0 <= remainder < D.
- R5: Digit selection keeps the partial remainder within 2d/3 in magnitude on every iteration, for divisors in each of the eight bands set by divisor bits 22..20, including both edges of every band.
- R6: A negative final partial remainder is corrected by adding one divisor and taking the decremented quotient. Exact divisions therefore return remainder 0 and the exact quotient.
- R7: The two on-the-fly quotient registers differ by exactly one unit in the last place at all times.
- R8: A `start` that arrives while `busy` is high is ignored. The running division uses the operands captured at acceptance, and its result is unchanged.
- R9: `done` is high for exactly one cycle per division. `quotient` and `remainder` hold their values until the next completion.
- R10: A `start` presented in the cycle where `done` is high is accepted, so divisions can run back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request a division with the operands on the data inputs |
| dividend | input | 24 | Dividend significand X, 0 < X < divisor |
| divisor | input | 24 | Divisor significand D with bit 23 set |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | 25 | floor(X * 2^25 / D) |
| remainder | output | 24 | X * 2^25 - quotient * D |

## Verification
The bench drives divisors at both edges of every leading-bit band, including the band edge at 13/16 where the threshold correction switches on. A wrong threshold there lets the remainder drift outside its bound, and the quotient then comes out wrong by many units. Exact divisions and dividends one unit below the divisor test the final correction step. A design that skips the correction, or takes the wrong register, returns a negative or oversized remainder and a quotient off by one. Start pulses during a running division and start pulses in the completion cycle test the handshake. These catch a controller that restarts with new operands, or that drops a back-to-back request.

// File: rtl/srt4_pkg.sv
// Shared types for the radix-4 SRT divider.
// Assumes: digits are 3-bit two's complement values in -2..+2.
package srt4_pkg;

    typedef logic signed [2:0] digit_t;

    localparam digit_t DIG_P2 = 3'b010;
    localparam digit_t DIG_P1 = 3'b001;
    localparam digit_t DIG_Z  = 3'b000;
    localparam digit_t DIG_M1 = 3'b111;
    localparam digit_t DIG_M2 = 3'b110;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIX  = 2'd2
    } srt4_state_e;

endpackage

// File: rtl/srt4_sel.sv
// Quotient digit selection for radix-4 SRT with digits -2..+2.
// Takes the shifted partial remainder p = 4w (two's complement,
// FRAC fraction bits) and the three divisor bits below the leading one.
// Thresholds, in eighths:
//   hi = 6 + (4*b2 + 2*b3 + b4) - c,  c = carry of (1.b2b3b4 + 3/16)
//   lo = 2 + b2
// Assumes: |w| <= 2d/3 on entry.
module srt4_sel
    import srt4_pkg::*;
#(
    parameter int W_W  = 28,
    parameter int FRAC = 25
) (
    input  logic [2:0]            d_lead,
    input  logic signed [W_W-1:0] p,
    output digit_t                q_dig
);
    localparam int SH = FRAC - 3;

    logic                  carry_c;
    logic [3:0]            hi_e;
    logic [3:0]            lo_e;
    logic signed [W_W-1:0] th_hi;
    logic signed [W_W-1:0] th_lo;

    // Derive both thresholds from the divisor bits, without any range compare
    always_comb begin
        // carry out of adding 3/16 to 0.1b2b3b4: set only when b2 and (b3 or b4)
        carry_c = d_lead[2] & (d_lead[1] | d_lead[0]);
        hi_e    = 4'd6 + {1'b0, d_lead} - {3'b000, carry_c};
        lo_e    = 4'd2 + {3'b000, d_lead[2]};
        th_hi   = signed'({{(W_W-4){1'b0}}, hi_e}) <<< SH;
        th_lo   = signed'({{(W_W-4){1'b0}}, lo_e}) <<< SH;
    end

    // Pick the digit by comparing the shifted remainder with the thresholds
    always_comb begin
        if (!p[W_W-1]) begin
            if (p >= th_hi)      q_dig = DIG_P2;
            else if (p >= th_lo) q_dig = DIG_P1;
            else                 q_dig = DIG_Z;
        end else begin
            if (p <= -th_hi)      q_dig = DIG_M2;
            else if (p <= -th_lo) q_dig = DIG_M1;
            else                  q_dig = DIG_Z;
        end
    end

endmodule

// File: rtl/srt4_otf.sv
// On-the-fly conversion of signed radix-4 digits to a binary quotient.
// Keeps qv (the quotient so far) and qmv (qv minus one ulp), and appends
// two bits to each on every step. No carry chain runs at the end.
// Assumes: the first digit is nonnegative (the dividend is positive).
module srt4_otf
    import srt4_pkg::*;
#(
    parameter int QR_W = 26
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            init,
    input  logic            step,
    input  digit_t          q_dig,
    output logic [QR_W-1:0] q_o,
    output logic [QR_W-1:0] qm_o
);
    logic [QR_W-1:0] qv;
    logic [QR_W-1:0] qmv;
    digit_t          dm1;
    logic            pos;

    // Two-bit tails: digit mod 4 for qv, (digit-1) mod 4 for qmv
    always_comb begin
        dm1 = q_dig - DIG_P1;
        pos = !q_dig[2] && (q_dig != DIG_Z);
    end

    // Shift and append into both registers
    always_ff @(posedge clk) begin
        if (!rst_n || init) begin
            qv  <= '0;
            qmv <= '1;
        end else if (step) begin
            qv  <= {(q_dig[2] ? qmv[QR_W-3:0] : qv[QR_W-3:0]), q_dig[1:0]};
            qmv <= {(pos ? qv[QR_W-3:0] : qmv[QR_W-3:0]), dm1[1:0]};
        end
    end

    assign q_o  = qv;
    assign qm_o = qmv;

    AST_QM_ULP: assert property (@(posedge clk) disable iff (!rst_n)
        (qv - qmv) == QR_W'(1)); // R7

endmodule

// File: rtl/srt4_ctrl.sv
// Sequencer: idle -> ITER recurrence steps -> one correction cycle.
// Assumes: start is ignored outside the idle state.
module srt4_ctrl
    import srt4_pkg::*;
#(
    parameter int ITER = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic fix,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(ITER);

    srt4_state_e state;
    logic [CW-1:0] cnt;

    // Decode the phase strobes from the state
    always_comb begin
        load = (state == ST_IDLE) && start;
        step = (state == ST_RUN);
        fix  = (state == ST_FIX);
        busy = (state != ST_IDLE);
    end

    // State, iteration counter and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            done  <= 1'b0;
        end else begin
            done <= (state == ST_FIX);
            case (state)
                ST_IDLE: if (start) begin
                    state <= ST_RUN;
                    cnt   <= '0;
                end
                ST_RUN: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == CW'(ITER-1)) state <= ST_FIX;
                end
                ST_FIX:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_FIX_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FIX) |-> ($past(state) == ST_RUN && $past(cnt) == CW'(ITER-1))); // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

endmodule

// File: rtl/srt4_divider.sv
// Radix-4 SRT significand divider (top).
// Inputs: divisor D with bit SIG_W-1 set (d in [1/2,1)) and dividend
// 0 < X < D. The first partial remainder is x/2, so |w| <= 2d/3 holds.
// Remainder word: FRAC = SIG_W+1 fraction bits and 3 integer bits.
// Outputs: quotient = floor(X*2^(SIG_W+1)/D), remainder = exact residue.
module srt4_divider
    import srt4_pkg::*;
#(
    parameter int SIG_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [SIG_W-1:0]   dividend,
    input  logic [SIG_W-1:0]   divisor,
    output logic               busy,
    output logic               done,
    output logic [SIG_W:0]     quotient,
    output logic [SIG_W-1:0]   remainder
);
    localparam int ITER = SIG_W/2 + 1;
    localparam int QR_W = 2 * ITER;
    localparam int FRAC = SIG_W + 1;
    localparam int W_W  = FRAC + 3;
    localparam int DN_W = SIG_W + 1;
    localparam int B_W  = W_W + 2;

    logic                  load, step, fix;
    logic [SIG_W-1:0]      d_r;
    logic signed [W_W-1:0] w_r;
    logic [QR_W-1:0]       quot_r;
    logic [SIG_W-1:0]      rem_r;

    logic [DN_W-1:0]       dn;
    logic signed [W_W-1:0] dn_w;
    logic signed [W_W-1:0] p;
    logic signed [W_W-1:0] mult;
    logic signed [W_W-1:0] w_next;
    logic signed [W_W-1:0] w_fin;
    logic [QR_W-1:0]       q_cur, qm_cur;
    digit_t                q_dig;
    logic [W_W-1:0]        absw;
    logic [B_W-1:0]        bnd_l, bnd_r;

    srt4_ctrl #(.ITER(ITER)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .load(load), .step(step), .fix(fix), .busy(busy), .done(done)
    );

    srt4_sel #(.W_W(W_W), .FRAC(FRAC)) u_sel (
        .d_lead(d_r[SIG_W-2 -: 3]), .p(p), .q_dig(q_dig)
    );

    srt4_otf #(.QR_W(QR_W)) u_otf (
        .clk(clk), .rst_n(rst_n), .init(load), .step(step),
        .q_dig(q_dig), .q_o(q_cur), .qm_o(qm_cur)
    );

    // Recurrence datapath: 4w minus or plus the selected divisor multiple
    always_comb begin
        dn     = {d_r, 1'b0};
        dn_w   = signed'({{(W_W-DN_W){1'b0}}, dn});
        p      = w_r <<< 2;
        if (q_dig == DIG_P2 || q_dig == DIG_M2)      mult = dn_w <<< 1;
        else if (q_dig == DIG_P1 || q_dig == DIG_M1) mult = dn_w;
        else                                         mult = '0;
        w_next = q_dig[2] ? (p + mult) : (p - mult);
        w_fin  = w_r[W_W-1] ? (w_r + dn_w) : w_r;
    end

    // Operand capture, remainder update and final correction
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_r    <= '0;
            w_r    <= '0;
            quot_r <= '0;
            rem_r  <= '0;
        end else if (load) begin
            d_r <= divisor;
            w_r <= signed'({{(W_W-SIG_W){1'b0}}, dividend});
        end else if (step) begin
            w_r <= w_next;
        end else if (fix) begin
            quot_r <= w_r[W_W-1] ? qm_cur : q_cur;
            rem_r  <= w_fin[SIG_W:1];
        end
    end

    assign quotient  = quot_r[SIG_W:0];
    assign remainder = rem_r;

    // Bound terms for the convergence check: 3|w| against 2d
    always_comb begin
        absw  = w_r[W_W-1] ? W_W'(-w_r) : W_W'(w_r);
        bnd_l = {2'b00, absw} + {1'b0, absw, 1'b0};
        bnd_r = {{(B_W-DN_W-1){1'b0}}, dn, 1'b0};
    end

    AST_W_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (bnd_l <= bnd_r)); // R5
    AST_FIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        fix |-> (w_fin[W_W-1:SIG_W+1] == '0 && !w_fin[0])); // R6
    AST_REM_LT_D: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rem_r < d_r)); // R4
    AST_QUOT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !quot_r[QR_W-1]); // R3
    AST_OPERAND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(d_r)); // R8

endmodule

// File: tb/sim_srt4_divider.sv
// Bench: behavioural cycle model of the handshake and the arithmetic,
// compared with the design at every falling edge, plus directed checks.
module sim_srt4_divider;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] dividend = '0;
    logic [23:0] divisor = 24'h800000;
    logic        busy, done;
    logic [24:0] quotient;
    logic [23:0] remainder;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit live = 1'b0;

    // reference model state
    bit          m_busy = 1'b0;
    bit          m_done = 1'b0;
    int          m_cnt = 0;
    longint      m_x = 0, m_d = 1;
    longint      m_q = 0, m_r = 0;

    srt4_divider u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
        .divisor(divisor), .busy(busy), .done(done),
        .quotient(quotient), .remainder(remainder)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic longint exp_q(input longint x, input longint d);
        return (x <<< 25) / d;
    endfunction

    // Cycle model: accept start when idle, finish 14 edges later
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_cnt = 0; m_q = 0; m_r = 0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                m_cnt++;
                if (m_cnt == 14) begin
                    m_busy = 0; m_done = 1;
                    m_q = exp_q(m_x, m_d);
                    m_r = (m_x <<< 25) - m_q * m_d;
                end
            end else if (start) begin
                m_busy = 1; m_cnt = 0;
                m_x = longint'(dividend); m_d = longint'(divisor);
            end
        end
    end

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (live) begin
            chk(busy == m_busy, "R2 busy", longint'(busy), longint'(m_busy));
            chk(done == m_done, "R9 done", longint'(done), longint'(m_done));
            chk(longint'(quotient) == m_q, "R3 quotient", longint'(quotient), m_q);
            chk(longint'(remainder) == m_r, "R4 remainder", longint'(remainder), m_r);
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (cycles > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic launch(input logic [23:0] x, input logic [23:0] d);
        dividend = x; divisor = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    task automatic run_div(input logic [23:0] x, input logic [23:0] d, input string tag);
        longint q, r;
        @(negedge clk);
        launch(x, d);
        wait_done();
        q = exp_q(longint'(x), longint'(d));
        r = (longint'(x) <<< 25) - q * longint'(d);
        chk(longint'(quotient) == q, tag, longint'(quotient), q);
        chk(longint'(remainder) == r && r < longint'(d), tag, longint'(remainder), r);
    endtask

    initial begin
        logic [23:0] dd, xx;
        longint qa;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        live = 1'b1;
        // R1: reset state
        chk(!busy && !done && quotient == 0 && remainder == 0, "R1 reset", longint'({busy, done}), 0);

        // R3 basic patterns
        run_div(24'h400000, 24'h800000, "R3 half");
        run_div(24'h000001, 24'hFFFFFF, "R3 tiny");
        run_div(24'hFFFFFE, 24'hFFFFFF, "R3 near one");
        run_div(24'h555555, 24'hC00000, "R3 mixed");

        // R5: both edges of every divisor band, several dividends
        for (int b = 0; b < 8; b++) begin
            for (int e = 0; e < 2; e++) begin
                dd = 24'h800000 + 24'(b) * 24'h100000 + (e == 1 ? 24'h0FFFFF : 24'h0);
                run_div(24'h000001, dd, "R5 band low x");
                run_div(dd - 24'd1, dd, "R5 band high x");
                run_div(24'((longint'(dd) * 2) / 3), dd, "R5 band 2/3 x");
            end
        end
        run_div(24'hCFFFFF, 24'hD00000, "R5 edge 13/16");
        run_div(24'h6AAAAA, 24'hCFFFFF, "R5 below 13/16");

        // R6: exact divisions and correction cases
        run_div(24'h500000, 24'hA00000, "R6 exact half");
        run_div(24'h9C0000, 24'hD00000, "R6 exact 3/4");
        run_div(24'h480000, 24'h900000, "R6 exact half 9/16");
        run_div(24'hEFFFFF, 24'hF00000, "R6 x=d-1");

        // R8: starts while busy are ignored
        @(negedge clk);
        launch(24'h123456, 24'h876543);
        dividend = 24'h000010; divisor = 24'hFFFF00; start = 1'b1;
        repeat (3) @(negedge clk);
        start = 1'b0;
        wait_done();
        qa = exp_q(64'h123456, 64'h876543);
        chk(longint'(quotient) == qa, "R8 ignored start", longint'(quotient), qa);

        // R10: start during the done cycle is accepted
        @(negedge clk);
        launch(24'h300000, 24'h900000);
        wait_done();
        launch(24'h700000, 24'hE00000);
        chk(busy == 1'b1, "R10 accept", longint'(busy), 1);
        wait_done();
        chk(longint'(quotient) == longint'(25'h1000000), "R10 result", longint'(quotient), 64'h1000000);

        // R9: outputs hold after the pulse
        repeat (5) @(negedge clk);
        chk(longint'(quotient) == 64'h1000000 && !done, "R9 hold", longint'(quotient), 64'h1000000);

        // R3/R4 random operands; R7 is watched by its assertion throughout
        for (int i = 0; i < 300; i++) begin
            dd = 24'h800000 | 24'($urandom() & 32'h7FFFFF);
            xx = 24'(1 + ($urandom() % (32'(dd) - 1)));
            run_div(xx, dd, "R3 R4 R7 random");
        end

        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule